// File: doc/BRIEF.md
# Chaotic Bit Harvester

The block turns the sample streams of a two-variable chaotic oscillator into a serial random bit stream. Each cycle it may receive one pair of 32-bit samples (the x and u state variables) qualified by a valid flag. From every accepted pair it keeps a single low-order bit of one channel. A two-state channel counter drives a multiplexer, so successive accepted pairs contribute x, u, x, u, and so on.

The harvested bits are grouped into consecutive pairs. A pair corrector removes bias: unequal pairs yield one bit, and equal pairs are dropped. Each corrected bit is XORed with an entropy bit from an external ring oscillator, which first passes through a synchronizer chain. The result is presented on a one-bit output with a one-cycle ready strobe. The whole chain runs only while the start input is high.

Top module: `chaos_bit_harvester`

## Requirements
- R1: While rst is high at a clock edge, rand_ready and rand_bit become 0 at that edge.
- R2: While start is low, no sample is consumed and rand_ready is 0 one edge later. Start low also returns the channel counter to x and discards any half-collected pair.
- R3: A sample pair is consumed only at an edge where start and smp_valid are both high. Cycles with smp_valid low leave the channel counter and the pair state unchanged.
- R4: After reset or start low, the first consumed pair contributes from smp_x and the next from smp_u. The channel then alternates on every consumed pair.
- R5: The harvested bit is bit TAP_BIT (default 0, the least significant mantissa bit) of the selected sample. All other sample bits have no effect.
- R6: Harvested bits form pairs (first, second) in consumption order. The pair 0,1 yields 0 and the pair 1,0 yields 1. The pairs 0,0 and 1,1 yield nothing, so rand_ready stays 0.
- R7: When a pair yields bit c at edge k, rand_bit becomes c XOR the ring_bit value sampled at edge k-2. rand_ready is 1 after that same edge.
- R8: rand_ready is high for exactly one cycle per produced bit and never in two consecutive cycles. While rand_ready is low, rand_bit keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run enable for the harvesting chain |
| smp_valid | input | 1 | Sample pair on smp_x/smp_u is valid this cycle |
| smp_x | input | SAMPLE_W (32) | Oscillator x-channel sample |
| smp_u | input | SAMPLE_W (32) | Oscillator u-channel sample |
| ring_bit | input | 1 | Ring-oscillator entropy bit, asynchronous to clk |
| rand_bit | output | 1 | Random output bit |
| rand_ready | output | 1 | rand_bit carries a new bit this cycle |

## Verification
The assertions assume that start and smp_valid are synchronous to clk and that each rand_ready is caused by a consumed pair. For that reason they tie a ready strobe to start and smp_valid having been high at the previous edge. ring_bit is the only input treated as asynchronous, and no property relates it to the output. The stimulus drives every input on the falling edge, so the values stay stable around each rising edge. It applies ring_bit as an ordinary level so that the two-edge synchronizer delay can be predicted exactly.

// File: rtl/cbh_pkg.sv
package cbh_pkg;

    localparam int SAMPLE_W = 32;
    localparam int NUM_CH   = 2;

    typedef enum logic {
        CH_X = 1'b0,
        CH_U = 1'b1
    } chan_e;

    // one harvested or corrected bit with its qualifier
    typedef struct packed {
        logic valid;
        logic value;
    } hbit_t;

    function automatic chan_e next_chan(chan_e c);
        return (c == CH_X) ? CH_U : CH_X;
    endfunction

    function automatic logic tap_bit(logic [SAMPLE_W-1:0] s, int unsigned pos);
        return s[pos];
    endfunction

    // pair corrector: unequal pair emits its first bit, equal pair emits nothing
    function automatic hbit_t pair_correct(logic pair_done, logic first, logic second);
        hbit_t r;
        r.valid = pair_done && (first != second);
        r.value = first;
        return r;
    endfunction

endpackage

// File: rtl/cbh_ring_sync.sv
module cbh_ring_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= 1'b0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/cbh_quantizer.sv
module cbh_quantizer
    import cbh_pkg::*;
#(
    parameter int TAP_BIT = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_x,
    input  logic [SAMPLE_W-1:0] smp_u,
    output hbit_t               harvested
);
    logic [SAMPLE_W-1:0] chans [NUM_CH];
    logic [NUM_CH-1:0]   taps;
    chan_e               sel;

    assign chans[0] = smp_x;
    assign chans[1] = smp_u;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_tap
            assign taps[g] = tap_bit(chans[g], TAP_BIT);
        end
    endgenerate

    // channel counter: R4
    always_ff @(posedge clk) begin
        if (rst || !start)  sel <= CH_X;
        else if (smp_valid) sel <= next_chan(sel);
    end

    always_comb begin
        harvested.valid = start && smp_valid;
        harvested.value = taps[sel];
    end
endmodule

// File: rtl/cbh_pair_corrector.sv
module cbh_pair_corrector
    import cbh_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  hbit_t din,
    output hbit_t dout
);
    logic have_first;
    logic first_bit;

    always_ff @(posedge clk) begin
        if (rst || !start) begin
            have_first <= 1'b0;
            first_bit  <= 1'b0;
        end else if (din.valid) begin
            if (!have_first) begin
                have_first <= 1'b1;
                first_bit  <= din.value;
            end else begin
                have_first <= 1'b0;
            end
        end
    end

    always_comb begin
        dout = pair_correct(have_first && din.valid, first_bit, din.value);
    end
endmodule

// File: rtl/chaos_bit_harvester.sv
module chaos_bit_harvester
    import cbh_pkg::*;
#(
    parameter int TAP_BIT     = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_x,
    input  logic [SAMPLE_W-1:0] smp_u,
    input  logic                ring_bit,
    output logic                rand_bit,
    output logic                rand_ready
);
    hbit_t harvested;
    hbit_t corrected;
    logic  ring_q;

    cbh_ring_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ring_bit),
        .sync_out (ring_q)
    );

    cbh_quantizer #(.TAP_BIT(TAP_BIT)) u_quant (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .smp_valid (smp_valid),
        .smp_x     (smp_x),
        .smp_u     (smp_u),
        .harvested (harvested)
    );

    cbh_pair_corrector u_corr (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .din   (harvested),
        .dout  (corrected)
    );

    // output stage: R7 mixing, R8 strobe and hold
    always_ff @(posedge clk) begin
        if (rst) begin
            rand_ready <= 1'b0;
            rand_bit   <= 1'b0;
        end else if (corrected.valid) begin
            rand_ready <= 1'b1;
            rand_bit   <= corrected.value ^ ring_q;
        end else begin
            rand_ready <= 1'b0;
        end
    end
endmodule

// File: rtl/cbh_checker.sv
module cbh_checker (
    input logic clk,
    input logic rst,
    input logic start,
    input logic smp_valid,
    input logic rand_bit,
    input logic rand_ready
);
    AST_READY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        rand_ready |-> $past(start)); // R2

    AST_STOP_SILENCES: assert property (@(posedge clk) disable iff (rst)
        !start |=> !rand_ready); // R2

    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        rand_ready |-> $past(smp_valid)); // R3

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        rand_ready |=> !rand_ready); // R8

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rand_ready |-> $stable(rand_bit)); // R8
endmodule

bind chaos_bit_harvester cbh_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .smp_valid  (smp_valid),
    .rand_bit   (rand_bit),
    .rand_ready (rand_ready)
);

// File: tb/chaos_bit_harvester_test.sv
`timescale 1ns/1ps
module chaos_bit_harvester_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_x = '0;
    logic [31:0] smp_u = '0;
    logic        ring_bit = 1'b0;
    logic        rand_bit;
    logic        rand_ready;

    always #2 clk = ~clk;

    chaos_bit_harvester uut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .smp_valid  (smp_valid),
        .smp_x      (smp_x),
        .smp_u      (smp_u),
        .ring_bit   (ring_bit),
        .rand_bit   (rand_bit),
        .rand_ready (rand_ready)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string phase  = "R1";

    // behavioural reference model
    bit m_use_u, m_have, m_first, m_ring1, m_ring2, m_ready, m_bit;

    always @(posedge clk) begin
        bit b;
        if (rst) begin
            m_use_u = 0; m_have = 0; m_first = 0;
            m_ring1 = 0; m_ring2 = 0; m_ready = 0; m_bit = 0;
        end else begin
            m_ready = 0;
            if (!start) begin
                m_use_u = 0; m_have = 0; m_first = 0;
            end else if (smp_valid) begin
                b = m_use_u ? smp_u[0] : smp_x[0];
                m_use_u = !m_use_u;
                if (!m_have) begin
                    m_have = 1; m_first = b;
                end else begin
                    m_have = 0;
                    if (m_first != b) begin
                        m_ready = 1;
                        m_bit   = m_first ^ m_ring2;
                    end
                end
            end
            m_ring2 = m_ring1;
            m_ring1 = ring_bit;
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(logic st, logic v, logic [31:0] x, logic [31:0] u, logic r);
        @(negedge clk);
        chk(phase, "rand_ready", rand_ready, m_ready);
        chk(phase, "rand_bit", rand_bit, m_bit);
        start = st; smp_valid = v; smp_x = x; smp_u = u; ring_bit = r;
    endtask

    function automatic logic [31:0] with_lsb(logic b);
        return {$urandom()} & 32'hFFFF_FFFE | {31'd0, b};
    endfunction

    // inverted upper bits make a wrong tap position visible: R5
    function automatic logic [31:0] lsb_only(logic b);
        return {{31{~b}}, b};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        phase = "R1";
        repeat (4) step(1'b1, 1'b1, $urandom(), $urandom(), 1'b1);
        @(negedge clk);
        chk("R1", "rand_ready after reset", rand_ready, 1'b0);
        chk("R1", "rand_bit after reset", rand_bit, 1'b0);
        rst = 1'b0; start = 1'b0; ring_bit = 1'b0;

        // R2 idle with valid samples
        phase = "R2";
        repeat (20) step(1'b0, 1'b1, $urandom(), $urandom(), 1'b0);

        // R4 channel order: x has 1, u has 0 -> pair 1,0 -> 1
        phase = "R4";
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 1'b1, with_lsb(1'b1), with_lsb(1'b0), 1'b0);
            step(1'b1, 1'b1, with_lsb(1'b1), with_lsb(1'b0), 1'b0);
            step(1'b1, 1'b0, $urandom(), $urandom(), 1'b0);
        end

        // R6 all four pair patterns
        phase = "R6";
        for (int rep = 0; rep < 3; rep++) begin
            for (int p = 0; p < 4; p++) begin
                step(1'b1, 1'b1, with_lsb(p[1]), $urandom(), 1'b0);
                step(1'b1, 1'b1, $urandom(), with_lsb(p[0]), 1'b0);
                step(1'b1, 1'b0, $urandom(), $urandom(), 1'b0);
            end
        end

        // R5 tap position
        phase = "R5";
        for (int p = 0; p < 8; p++) begin
            step(1'b1, 1'b1, lsb_only(p[1]), lsb_only(~p[1]), 1'b0);
            step(1'b1, 1'b1, lsb_only(p[0]), lsb_only(~p[0]), 1'b0);
        end
        step(1'b1, 1'b0, '0, '0, 1'b0);

        // R3 gaps in valid with garbage data
        phase = "R3";
        for (int i = 0; i < 200; i++)
            step(1'b1, 1'($urandom() % 2), $urandom(), $urandom(), 1'b0);

        // R7 ring mixing
        phase = "R7";
        for (int i = 0; i < 300; i++)
            step(1'b1, 1'b1, $urandom(), $urandom(), 1'($urandom() % 2));

        // R2 start drop in the middle of a pair
        phase = "R2";
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 1'b1, with_lsb(1'b1), with_lsb(1'b1), 1'b0);
            step(1'b0, 1'b1, with_lsb(1'b0), with_lsb(1'b0), 1'b0);
            step(1'b1, 1'b1, with_lsb(1'b0), with_lsb(1'b1), 1'b0);
            step(1'b1, 1'b1, with_lsb(1'b0), with_lsb(1'b1), 1'b0);
        end
        for (int i = 0; i < 300; i++)
            step(1'($urandom() % 5 != 0), 1'b1, $urandom(), $urandom(), 1'($urandom() % 2));

        // R8 mixed random traffic
        phase = "R8";
        for (int i = 0; i < 500; i++)
            step(1'($urandom() % 8 != 0), 1'($urandom() % 3 != 0),
                 $urandom(), $urandom(), 1'($urandom() % 2));
        repeat (4) step(1'b0, 1'b0, '0, '0, 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule